// File: doc/BRIEF.md
# I2C Own-Address and Extension-Code Interrupt Unit

This unit sits behind an I2C bus front end that has already filtered the pins and turned bus activity into single-cycle strobes in the system clock domain: a start flag, a stop flag, an SCL falling-edge flag and the SDA value sampled for that clock. The unit counts serial clocks within each byte and checks the first byte after every start (or repeated start) against a programmable 7-bit own address. It also recognises extension codes. When the transfer is addressed to this node, it raises one interrupt per byte at a programmable point. It can also raise an interrupt when a stop condition appears.

There is no stream with back-pressure here. Every input is a one-cycle event strobe or a level control bit, and the unit accepts an event in every cycle, so no valid/ready handshake exists and an event can never be stalled. All outputs are registered and change in the cycle after the strobe that causes them. If start and stop arrive in the same cycle, start has priority over the counter and the flags. A stop or start in the same cycle as an SCL fall cancels that fall.

Top module: `i2c_addr_hit_irq`

## Requirements
- R1: The own-address register resets to 0x00. A write through `own_wr` stores `own_wdata[7:1]`. Bit 0 of `own_addr` always reads 0, whatever was written.
- R2: `bit_cnt` resets to 0. Start, repeated start or stop returns it to 0. Each SCL fall adds 1, and the fall after count 9 gives 1. The new value is visible the cycle after the strobe.
- R3: Bits arrive MSB first. On the 8th SCL fall after a start, `addr_match` becomes 1 exactly when byte bits 7..1 equal `own_addr[7:1]`. The R/W bit (byte bit 0) takes no part in the comparison and is presented on `rw_dir`.
- R4: On that same 8th fall, `ext_code` becomes 1 when byte bits 7..4 are 0000 or 1111, whether or not the address matches.
- R5: An address byte that matches or is an extension code pulses `irq` the cycle after the 8th SCL fall when `wait9_sel` = 0, or after the 9th fall when `wait9_sel` = 1. Its other falls give no interrupt.
- R6: After an address hit, every following byte also interrupts at the selected 8th or 9th fall, until a stop or a new start.
- R7: After an address byte that neither matches nor is an extension code, no byte interrupt occurs until the next start.
- R8: A stop strobe pulses `irq` the next cycle when `stop_irq_en` = 1, and gives no interrupt when it is 0.
- R9: `irq` is high for one cycle per causing strobe and is only ever caused by an SCL fall or a stop.
- R10: A start strobe clears `addr_match`, `ext_code` and `rw_dir` in the next cycle.
- R11: From reset until the first start, SCL falls raise no interrupt and leave `addr_match` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_wr | input | 1 | Write strobe for the own-address register |
| own_wdata | input | 8 | Write data; address in bits 7..1 |
| own_addr | output | 8 | Own-address register readback, bit 0 always 0 |
| start_det | input | 1 | Start or repeated-start strobe |
| stop_det | input | 1 | Stop strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_bit | input | 1 | SDA value belonging to the current SCL fall |
| wait9_sel | input | 1 | 0: byte interrupt at 8th fall, 1: at 9th fall |
| stop_irq_en | input | 1 | Enables the interrupt on stop |
| irq | output | 1 | One-cycle interrupt pulse |
| addr_match | output | 1 | Last address byte matched the own address |
| ext_code | output | 1 | Last address byte was an extension code |
| rw_dir | output | 1 | R/W bit of the last address byte |
| bit_cnt | output | 4 | Serial clocks seen in the current byte, 0 to 9 |

## Verification
A clock counter that is off by one shows up within a single byte. The interrupt then lands one fall early or late against `wait9_sel`, and `bit_cnt` reads the wrong value after the next strobe. A wrong address-phase or mute state shows within two bytes. The address flags rise on a data byte, or a data byte after a mismatch raises an interrupt, or one after a hit stays silent. A start or stop that fails to clear state shows in the very next cycle, through `bit_cnt` and the address flags.

// File: rtl/i2c_ahi_pkg.sv
package i2c_ahi_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned BYTE_W  = ADDR_W + 1;
  localparam int unsigned ACK_POS = BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(ACK_POS + 1);
  localparam int unsigned EXT_W   = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_BYTE = cnt_t'(BYTE_W);
  localparam cnt_t CNT_ACK  = cnt_t'(ACK_POS);
  localparam cnt_t CNT_ONE  = cnt_t'(1);

  typedef struct packed {
    logic match;
    logic ext;
    logic rw;
  } addr_result_t;
endpackage

// File: rtl/i2c_ahi_bit_counter.sv
module i2c_ahi_bit_counter
  import i2c_ahi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_fall,
  output cnt_t cnt_q,
  output cnt_t cnt_nxt,
  output logic fall_evt
);
  assign fall_evt = scl_fall & ~start_det & ~stop_det;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start_det || stop_det)
      cnt_nxt = '0;
    else if (scl_fall)
      cnt_nxt = (cnt_q >= CNT_ACK) ? CNT_ONE : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/i2c_ahi_addr_decoder.sv
module i2c_ahi_addr_decoder
  import i2c_ahi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              fall_evt,
  input  cnt_t              cnt_nxt,
  input  logic              sda_bit,
  input  logic              own_wr,
  input  logic [BYTE_W-1:0] own_wdata,
  output logic [BYTE_W-1:0] own_q,
  output logic              addr_done,
  output logic              hit_now,
  output logic              muted_q,
  output addr_result_t      result_q
);
  localparam logic [BYTE_W-1:0] OWN_MASK = {{ADDR_W{1'b1}}, 1'b0};

  logic [ADDR_W-1:0] shift_q;
  logic              addr_phase_q;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] rx_addr;
  logic [EXT_W-1:0]  rx_top;
  logic              match_c;
  logic              ext_c;

  assign rx_byte   = {shift_q, sda_bit};
  assign rx_addr   = rx_byte[BYTE_W-1:1];
  assign rx_top    = rx_addr[ADDR_W-1 -: EXT_W];
  assign match_c   = (rx_addr == own_q[BYTE_W-1:1]);
  assign ext_c     = (&rx_top) | ~(|rx_top);
  assign addr_done = fall_evt & addr_phase_q & (cnt_nxt == CNT_BYTE);
  assign hit_now   = addr_done & (match_c | ext_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= '0;
    else if (own_wr) own_q <= own_wdata & OWN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (fall_evt) shift_q <= rx_byte[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_phase_q <= 1'b0;
      muted_q      <= 1'b1;
      result_q     <= '0;
    end else if (start_det) begin
      addr_phase_q <= 1'b1;
      muted_q      <= 1'b0;
      result_q     <= '0;
    end else if (stop_det) begin
      addr_phase_q <= 1'b0;
      muted_q      <= 1'b1;
    end else if (addr_done) begin
      addr_phase_q <= 1'b0;
      muted_q      <= ~(match_c | ext_c);
      result_q     <= '{match: match_c, ext: ext_c, rw: rx_byte[0]};
    end
  end
endmodule

// File: rtl/i2c_ahi_irq_gen.sv
module i2c_ahi_irq_gen
  import i2c_ahi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  input  cnt_t cnt_nxt,
  input  logic wait9_sel,
  input  logic stop_det,
  input  logic stop_irq_en,
  input  logic muted_q,
  input  logic addr_done,
  input  logic hit_now,
  output logic irq
);
  cnt_t fire_pt;
  logic at_point;
  logic allowed;
  logic byte_evt;
  logic stop_evt;

  assign fire_pt  = wait9_sel ? CNT_ACK : CNT_BYTE;
  assign at_point = fall_evt & (cnt_nxt == fire_pt);
  assign allowed  = addr_done ? hit_now : ~muted_q;
  assign byte_evt = at_point & allowed;
  assign stop_evt = stop_det & stop_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= byte_evt | stop_evt;
  end
endmodule

// File: rtl/i2c_addr_hit_irq.sv
module i2c_addr_hit_irq
  import i2c_ahi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_wr,
  input  logic [BYTE_W-1:0] own_wdata,
  output logic [BYTE_W-1:0] own_addr,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_fall,
  input  logic              sda_bit,
  input  logic              wait9_sel,
  input  logic              stop_irq_en,
  output logic              irq,
  output logic              addr_match,
  output logic              ext_code,
  output logic              rw_dir,
  output logic [CNT_W-1:0]  bit_cnt
);
  cnt_t         cnt_q;
  cnt_t         cnt_nxt;
  logic         fall_evt;
  logic         addr_done;
  logic         hit_now;
  logic         muted_q;
  addr_result_t result_q;

  i2c_ahi_bit_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_fall  (scl_fall),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .fall_evt  (fall_evt)
  );

  i2c_ahi_addr_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .fall_evt  (fall_evt),
    .cnt_nxt   (cnt_nxt),
    .sda_bit   (sda_bit),
    .own_wr    (own_wr),
    .own_wdata (own_wdata),
    .own_q     (own_addr),
    .addr_done (addr_done),
    .hit_now   (hit_now),
    .muted_q   (muted_q),
    .result_q  (result_q)
  );

  i2c_ahi_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_evt    (fall_evt),
    .cnt_nxt     (cnt_nxt),
    .wait9_sel   (wait9_sel),
    .stop_det    (stop_det),
    .stop_irq_en (stop_irq_en),
    .muted_q     (muted_q),
    .addr_done   (addr_done),
    .hit_now     (hit_now),
    .irq         (irq)
  );

  assign bit_cnt    = cnt_q;
  assign addr_match = result_q.match;
  assign ext_code   = result_q.ext;
  assign rw_dir     = result_q.rw;
endmodule

// File: rtl/i2c_addr_hit_irq_chk.sv
module i2c_addr_hit_irq_chk
  import i2c_ahi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              own_wr,
  input logic [BYTE_W-1:0] own_wdata,
  input logic [BYTE_W-1:0] own_addr,
  input logic              start_det,
  input logic              stop_det,
  input logic              scl_fall,
  input logic              wait9_sel,
  input logic              stop_irq_en,
  input logic              irq,
  input logic              addr_match,
  input logic              ext_code,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    own_wr |=> own_addr == {$past(own_wdata[BYTE_W-1:1]), 1'b0}); // R1

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_ACK); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == '0) && !addr_match && !ext_code); // R10

  AST_MATCH_AT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> bit_cnt == CNT_BYTE); // R3

  AST_BYTE_IRQ_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(stop_det)) |-> bit_cnt == ($past(wait9_sel) ? CNT_ACK : CNT_BYTE)); // R5

  AST_STOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && stop_irq_en) |=> irq); // R8

  AST_NO_STOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !stop_irq_en && !scl_fall) |=> !irq); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(scl_fall || stop_det)); // R9
endmodule

bind i2c_addr_hit_irq i2c_addr_hit_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .own_wr      (own_wr),
  .own_wdata   (own_wdata),
  .own_addr    (own_addr),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .scl_fall    (scl_fall),
  .wait9_sel   (wait9_sel),
  .stop_irq_en (stop_irq_en),
  .irq         (irq),
  .addr_match  (addr_match),
  .ext_code    (ext_code),
  .bit_cnt     (bit_cnt)
);

// File: tb/i2c_addr_hit_irq_tb.sv
module i2c_addr_hit_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       own_wr = 1'b0;
  logic [7:0] own_wdata = '0;
  logic [7:0] own_addr;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic       scl_fall = 1'b0;
  logic       sda_bit = 1'b0;
  logic       wait9_sel = 1'b0;
  logic       stop_irq_en = 1'b0;
  logic       irq;
  logic       addr_match;
  logic       ext_code;
  logic       rw_dir;
  logic [3:0] bit_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_hit_irq u_dut (
    .clk(clk), .rst_n(rst_n), .own_wr(own_wr), .own_wdata(own_wdata),
    .own_addr(own_addr), .start_det(start_det), .stop_det(stop_det),
    .scl_fall(scl_fall), .sda_bit(sda_bit), .wait9_sel(wait9_sel),
    .stop_irq_en(stop_irq_en), .irq(irq), .addr_match(addr_match),
    .ext_code(ext_code), .rw_dir(rw_dir), .bit_cnt(bit_cnt)
  );

  // {own7, address byte, wait9, expected match, expected extension code}
  localparam logic [17:0] VEC [6] = '{
    {7'h2A, 8'h54, 1'b0, 1'b1, 1'b0},
    {7'h2A, 8'h55, 1'b1, 1'b1, 1'b0},
    {7'h2A, 8'h56, 1'b0, 1'b0, 1'b0},
    {7'h2A, 8'h02, 1'b0, 1'b0, 1'b1},
    {7'h2A, 8'hF1, 1'b1, 1'b0, 1'b1},
    {7'h00, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_own(input logic [7:0] v);
    own_wdata = v; own_wr = 1'b1;
    @(negedge clk);
    own_wr = 1'b0;
  endtask

  task automatic do_start();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic do_stop(output logic seen);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    seen = irq;
  endtask

  task automatic send_bit(input logic b, output logic seen);
    sda_bit = b; scl_fall = 1'b1;
    @(negedge clk);
    scl_fall = 1'b0;
    seen = irq;
  endtask

  // mask bit i records irq after fall i+1; 9th fall carries ACK (0)
  task automatic send_byte(input logic [7:0] v, output logic [8:0] mask);
    logic s;
    mask = '0;
    for (int i = 0; i < 8; i++) begin
      send_bit(v[7-i], s);
      mask[i] = s;
    end
    send_bit(1'b0, s);
    mask[8] = s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] m;
    logic       s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(own_addr == 8'h00, "R1 reset own", own_addr, 0);
    check(bit_cnt == 0 && !irq, "R2 reset cnt/irq", {bit_cnt, irq}, 0);
    check(!addr_match && !ext_code, "R3 reset flags", {addr_match, ext_code}, 0);

    // bit 0 of the own-address register never sticks
    write_own(8'hFF);
    check(own_addr == 8'hFE, "R1 lsb zero", own_addr, 8'hFE);

    // no start yet: byte that would match gives nothing
    write_own(8'h54);
    send_byte(8'h54, m);
    check(m == 9'h0, "R11 no irq before start", m, 0);
    check(!addr_match, "R11 no match before start", addr_match, 0);

    // table of address bytes
    for (int i = 0; i < 6; i++) begin
      logic [6:0] o7;
      logic [7:0] ab;
      logic       w9, em, ee;
      logic [8:0] em_mask;
      {o7, ab, w9, em, ee} = VEC[i];
      write_own({o7, 1'b0});
      wait9_sel = w9;
      do_start();
      check(!addr_match && !ext_code && !rw_dir, "R10 start clears", {addr_match, ext_code, rw_dir}, 0);
      send_byte(ab, m);
      em_mask = (em || ee) ? (w9 ? 9'h100 : 9'h080) : 9'h000;
      check(m == em_mask, "R5 irq point", m, em_mask);
      check(addr_match == em, "R3 match", addr_match, em);
      check(ext_code == ee, "R4 ext code", ext_code, ee);
      check(rw_dir == ab[0], "R3 rw dir", rw_dir, ab[0]);
      do_stop(s);
    end
    wait9_sel = 1'b0;

    // data bytes after a hit
    write_own(8'h54);
    do_start();
    send_byte(8'h54, m);
    check(m == 9'h080 && addr_match, "R5 hit", m, 9'h080);
    check(bit_cnt == 9, "R2 count 9", bit_cnt, 9);
    send_byte(8'hA5, m);
    check(m == 9'h080, "R6 data irq", m, 9'h080);
    check(addr_match && !ext_code, "R3 flags hold on data", {addr_match, ext_code}, 2);
    wait9_sel = 1'b1;
    send_byte(8'h0F, m);
    check(m == 9'h100, "R6 data irq at 9", m, 9'h100);
    wait9_sel = 1'b0;
    send_bit(1'b1, s);
    check(bit_cnt == 1, "R2 wrap to 1", bit_cnt, 1);
    send_bit(1'b0, s);
    send_bit(1'b1, s);
    check(bit_cnt == 3, "R2 count 3", bit_cnt, 3);

    // repeated start mid-byte
    do_start();
    check(bit_cnt == 0, "R2 repeated start clears", bit_cnt, 0);
    check(!addr_match, "R10 repeated start clears match", addr_match, 0);
    send_byte(8'h56, m);
    check(m == 9'h0 && !addr_match, "R7 miss", m, 0);
    send_byte(8'h54, m);
    check(m == 9'h0, "R7 muted data", m, 0);
    check(!addr_match, "R7 data not treated as address", addr_match, 0);

    // stop interrupts
    stop_irq_en = 1'b1;
    do_stop(s);
    check(s == 1'b1, "R8 stop irq", s, 1);
    check(bit_cnt == 0, "R2 stop clears", bit_cnt, 0);
    @(negedge clk);
    check(!irq, "R9 single pulse", irq, 0);
    stop_irq_en = 1'b0;
    do_stop(s);
    check(s == 1'b0, "R8 stop masked", s, 0);

    // after stop, bytes stay silent until next start
    send_byte(8'h54, m);
    check(m == 9'h0, "R7 silent after stop", m, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule